// File: doc/BRIEF.md
# Strobed Port Handshake Controller

This block runs the handshake for one 8-bit parallel port group that moves bytes between a CPU and a peripheral. A parameter fixes the direction at build time. As an input port, the peripheral pulls its strobe low to capture the pin data into a holding latch. That capture raises a buffer-full flag. Once the strobe returns high, an interrupt request goes up to the CPU. The flag drops when the CPU finishes reading the port.

As an output port, a CPU write loads a data latch that then drives the pins. An active-low buffer-full line tells the peripheral that new data is waiting. The peripheral clears that line by pulling its acknowledge low. When the acknowledge returns high, an interrupt asks the CPU for the next byte.

An interrupt-enable flag gates the interrupt in both directions. Software writes that flag with a single-bit set/reset command that names a port-C bit position. The flag listens to bit 4 for the first group as input, bit 6 for the first group as output, and bit 2 for the second group in either direction. The CPU read, CPU write and peripheral strobe/acknowledge inputs all pass through a two-flop synchronizer before their edges are detected.

Top module: `strobed_port_ctrl`

## Requirements
- R1: After reset the data latch is 0, the interrupt request is 0, the enable flag is clear and the pins are not driven. The buffer flag is 0 as an input port and 1 (released) as an output port.
- R2: As an input port, while the synchronized strobe is low the data latch loads the pin data, and `port_data` shows it.
- R3: As an input port, the buffer flag goes to 1 on a falling strobe edge and returns to 0 on the rising edge of the CPU read.
- R4: As an input port, `intr` is 1 exactly when the synchronized strobe is high, the buffer flag is 1 and the enable flag is set.
- R5: As an output port, the rising edge of the CPU write drives the buffer flag to 0 (asserted), and a falling acknowledge edge returns it to 1. While the write is low, the latch takes `cpu_wdata`.
- R6: As an output port, `intr` is set by a rising acknowledge edge while the buffer flag is 1 and the enable flag is set. It is cleared by a falling edge of the CPU write.
- R7: A set/reset command with `bsr_valid`=1 writes `bsr_val` into the enable flag only when `bsr_bit` equals the group's index: 4 for the first group as input, 6 for the first group as output, 2 for the second group. Any other index leaves the flag unchanged.
- R8: As an output port, `port_oe` is 0 until the first completed write and 1 from then on. The latch keeps driving the last written byte while `cpu_wdata` changes.
- R9: A strobe change first affects the buffer flag at the third rising clock edge after it: two edges for the synchronizer and one for the flag register.
- R10: As an input port, the latch follows the pins while the strobe stays low. It holds its value after the strobe returns high, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| periph_hs_n | input | 1 | Peripheral strobe (input port) or acknowledge (output port), active low |
| pin_in | input | WIDTH | Pin data sampled as an input port |
| cpu_wdata | input | WIDTH | CPU write data |
| bsr_valid | input | 1 | Single-bit set/reset command valid |
| bsr_bit | input | 3 | Port-C bit index named by the command |
| bsr_val | input | 1 | Value written by the command |
| port_data | output | WIDTH | Data latch: read data (input) or pin drive (output) |
| port_oe | output | 1 | Pin drive enable |
| buf_flag | output | 1 | Input buffer full (active high) or output buffer full (active low) |
| intr | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach is an interrupt that must stay low even though a byte is pending. It needs the enable flag in a known state while the buffer flag is set and the strobe is high. The stimulus reaches it by capturing a byte with the enable clear, then issuing a set/reset command to a neighbouring bit index, and only afterwards to the right one. The interrupt is watched after each step. On the output side, the enable is raised and a command to a wrong index follows. A later acknowledge must still raise the interrupt, which shows the stray command left the flag alone.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int HS_SEL_W = 3;

    typedef struct packed {
        logic flag;     // IBF (input) or OBF_n (output)
        logic intr;     // registered interrupt (output direction)
        logic inte;     // interrupt enable
        logic written;  // first write done (output direction)
    } hs_ctl_t;
endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/hs_bsr_decode.sv
module hs_bsr_decode
    import hs_pkg::*;
#(
    parameter int INTE_IDX = 4
) (
    input  logic                bsr_valid,
    input  logic [HS_SEL_W-1:0] bsr_bit,
    input  logic                bsr_val,
    output logic                inte_set,
    output logic                inte_clr
);
    localparam logic [HS_SEL_W-1:0] IDX = HS_SEL_W'(INTE_IDX);

    logic hit;
    assign hit      = bsr_valid && (bsr_bit == IDX);
    assign inte_set = hit &  bsr_val;
    assign inte_clr = hit & ~bsr_val;
endmodule

// File: rtl/hs_core.sv
module hs_core
    import hs_pkg::*;
#(
    parameter int   WIDTH    = 8,
    parameter logic IS_INPUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_rise,
    input  logic             wr_lvl,
    input  logic             wr_rise,
    input  logic             wr_fall,
    input  logic             hs_lvl,
    input  logic             hs_rise,
    input  logic             hs_fall,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] cpu_wdata,
    input  logic             inte_set,
    input  logic             inte_clr,
    output logic [WIDTH-1:0] data_q,
    output logic             flag,
    output logic             intr,
    output logic             oe
);
    localparam hs_ctl_t CTL_RST = '{flag: ~IS_INPUT, intr: 1'b0, inte: 1'b0, written: 1'b0};

    hs_ctl_t          ctl_d, ctl_q;
    logic [WIDTH-1:0] data_d;

    always_comb begin
        ctl_d  = ctl_q;
        data_d = data_q;
        if (inte_set) ctl_d.inte = 1'b1;
        else if (inte_clr) ctl_d.inte = 1'b0;
        if (IS_INPUT) begin
            if (!hs_lvl) data_d = pin_in;
            if (rd_rise) ctl_d.flag = 1'b0;
            if (hs_fall) ctl_d.flag = 1'b1;
        end else begin
            if (!wr_lvl) data_d = cpu_wdata;
            if (wr_rise) ctl_d.written = 1'b1;
            if (hs_fall) ctl_d.flag = 1'b1;
            if (wr_rise) ctl_d.flag = 1'b0;
            if (hs_rise && ctl_q.flag && ctl_q.inte) ctl_d.intr = 1'b1;
            if (wr_fall) ctl_d.intr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RST;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            data_q <= data_d;
        end
    end

    assign flag = ctl_q.flag;

    generate
        if (IS_INPUT) begin : g_in
            logic unused_in;
            assign unused_in = ^{wr_lvl, wr_rise, wr_fall, hs_rise, cpu_wdata, ctl_q.intr, ctl_q.written};
            assign intr = hs_lvl & ctl_q.flag & ctl_q.inte;
            assign oe   = 1'b0;

            // R3
            ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ctl_q.flag) |-> $past(hs_fall));
        end else begin : g_out
            logic unused_out;
            assign unused_out = ^{rd_rise, pin_in};
            assign intr = ctl_q.intr;
            assign oe   = ctl_q.written;

            // R5
            obf_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ctl_q.flag) |-> $past(wr_rise));
            // R6
            intr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_fall |=> !intr);
        end
    endgenerate

    // R7
    inte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inte_set || inte_clr) |=> $stable(ctl_q.inte));
endmodule

// File: rtl/strobed_port_ctrl.sv
module strobed_port_ctrl
    import hs_pkg::*;
#(
    parameter int   WIDTH       = 8,
    parameter logic IS_INPUT    = 1'b1,
    parameter logic GROUP_A     = 1'b1,
    parameter int   SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_rd_n,
    input  logic                cpu_wr_n,
    input  logic                periph_hs_n,
    input  logic [WIDTH-1:0]    pin_in,
    input  logic [WIDTH-1:0]    cpu_wdata,
    input  logic                bsr_valid,
    input  logic [HS_SEL_W-1:0] bsr_bit,
    input  logic                bsr_val,
    output logic [WIDTH-1:0]    port_data,
    output logic                port_oe,
    output logic                buf_flag,
    output logic                intr
);
    localparam int INTE_IDX = GROUP_A ? (IS_INPUT ? 4 : 6) : 2;

    logic rd_lvl, rd_rise, rd_fall;
    logic wr_lvl, wr_rise, wr_fall;
    logic hs_lvl, hs_rise, hs_fall;
    logic inte_set, inte_clr;
    logic unused_rd;

    assign unused_rd = ^{rd_lvl, rd_fall};

    hs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .raw(cpu_rd_n),
        .lvl(rd_lvl), .rise(rd_rise), .fall(rd_fall));

    hs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .raw(cpu_wr_n),
        .lvl(wr_lvl), .rise(wr_rise), .fall(wr_fall));

    hs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
        .clk(clk), .rst_n(rst_n), .raw(periph_hs_n),
        .lvl(hs_lvl), .rise(hs_rise), .fall(hs_fall));

    hs_bsr_decode #(.INTE_IDX(INTE_IDX)) u_bsr (
        .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
        .inte_set(inte_set), .inte_clr(inte_clr));

    hs_core #(.WIDTH(WIDTH), .IS_INPUT(IS_INPUT)) u_core (
        .clk(clk), .rst_n(rst_n),
        .rd_rise(rd_rise),
        .wr_lvl(wr_lvl), .wr_rise(wr_rise), .wr_fall(wr_fall),
        .hs_lvl(hs_lvl), .hs_rise(hs_rise), .hs_fall(hs_fall),
        .pin_in(pin_in), .cpu_wdata(cpu_wdata),
        .inte_set(inte_set), .inte_clr(inte_clr),
        .data_q(port_data), .flag(buf_flag), .intr(intr), .oe(port_oe));
endmodule

// File: tb/strobed_port_ctrl_bench.sv
`timescale 1ns/1ps
module strobed_port_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // input-direction DUT, first group (enable index 4)
    logic       i_rd_n = 1, i_wr_n = 1, i_hs_n = 1, i_bv = 0, i_bval = 0;
    logic [7:0] i_pin = 0, i_wd = 0;
    logic [2:0] i_bbit = 0;
    logic [7:0] i_data;
    logic       i_oe, i_flag, i_intr;

    // output-direction DUT, second group (enable index 2)
    logic       o_rd_n = 1, o_wr_n = 1, o_hs_n = 1, o_bv = 0, o_bval = 0;
    logic [7:0] o_pin = 0, o_wd = 0;
    logic [2:0] o_bbit = 0;
    logic [7:0] o_data;
    logic       o_oe, o_flag, o_intr;

    strobed_port_ctrl #(.WIDTH(8), .IS_INPUT(1'b1), .GROUP_A(1'b1)) u_strobed_port_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_rd_n(i_rd_n), .cpu_wr_n(i_wr_n),
        .periph_hs_n(i_hs_n), .pin_in(i_pin), .cpu_wdata(i_wd),
        .bsr_valid(i_bv), .bsr_bit(i_bbit), .bsr_val(i_bval),
        .port_data(i_data), .port_oe(i_oe), .buf_flag(i_flag), .intr(i_intr));

    strobed_port_ctrl #(.WIDTH(8), .IS_INPUT(1'b0), .GROUP_A(1'b0)) u_strobed_port_ctrl_out (
        .clk(clk), .rst_n(rst_n), .cpu_rd_n(o_rd_n), .cpu_wr_n(o_wr_n),
        .periph_hs_n(o_hs_n), .pin_in(o_pin), .cpu_wdata(o_wd),
        .bsr_valid(o_bv), .bsr_bit(o_bbit), .bsr_val(o_bval),
        .port_data(o_data), .port_oe(o_oe), .buf_flag(o_flag), .intr(o_intr));

    typedef struct {
        bit         is_out;
        string      rid;
        logic       flag;
        logic       irq;
        logic       oe;
        logic [7:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input bit is_out, input string rid, input logic flag,
                             input logic irq, input logic oe, input logic [7:0] data);
        exp_t e;
        e.is_out = is_out; e.rid = rid; e.flag = flag; e.irq = irq; e.oe = oe; e.data = data;
        exp_q.push_back(e);
    endtask

    // monitor: pops expectations at the falling edge after they were queued
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            logic [10:0] act, expv;
            e = exp_q.pop_front();
            act  = e.is_out ? {o_flag, o_intr, o_oe, o_data} : {i_flag, i_intr, i_oe, i_data};
            expv = {e.flag, e.irq, e.oe, e.data};
            checks++;
            if (act !== expv) begin
                errors++;
                $display("FAIL %s: flag/intr/oe/data actual %b/%b/%b/%h expected %b/%b/%b/%h",
                         e.rid, act[10], act[9], act[8], act[7:0],
                         expv[10], expv[9], expv[8], expv[7:0]);
            end
        end
    end

    bit done = 0;

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_st(0, "R1", 0, 0, 0, 8'h00);
        expect_st(1, "R1", 1, 0, 0, 8'h00);
        expect_st(1, "R8 no drive before write", 1, 0, 0, 8'h00);

        // ---------- input direction ----------
        i_pin = 8'hA5; i_hs_n = 1'b0;
        tick(2);
        expect_st(0, "R9 not yet", 0, 0, 0, 8'h00);
        tick(1);
        expect_st(0, "R2 R3 R9 capture", 1, 0, 0, 8'hA5);
        i_pin = 8'h3C;
        tick(3);
        expect_st(0, "R10 follow", 1, 0, 0, 8'h3C);
        i_hs_n = 1'b1;
        tick(3);
        expect_st(0, "R4 enable clear", 1, 0, 0, 8'h3C);
        i_pin = 8'hFF;
        tick(3);
        expect_st(0, "R10 hold", 1, 0, 0, 8'h3C);
        i_bv = 1; i_bbit = 3'd3; i_bval = 1;
        tick(1);
        i_bv = 0;
        tick(2);
        expect_st(0, "R7 wrong index", 1, 0, 0, 8'h3C);
        i_bv = 1; i_bbit = 3'd4; i_bval = 1;
        tick(1);
        i_bv = 0;
        tick(1);
        expect_st(0, "R4 R7 enabled", 1, 1, 0, 8'h3C);
        i_rd_n = 1'b0;
        tick(3);
        expect_st(0, "R3 held during read", 1, 1, 0, 8'h3C);
        i_rd_n = 1'b1;
        tick(3);
        expect_st(0, "R3 read clears", 0, 0, 0, 8'h3C);
        i_bv = 1; i_bbit = 3'd4; i_bval = 0;
        tick(1);
        i_bv = 0;
        i_pin = 8'h11; i_hs_n = 1'b0;
        tick(3);
        i_hs_n = 1'b1;
        tick(3);
        expect_st(0, "R4 R7 disabled", 1, 0, 0, 8'h11);

        // ---------- output direction ----------
        o_wd = 8'h5A; o_wr_n = 1'b0;
        tick(3);
        o_wr_n = 1'b1;
        tick(3);
        expect_st(1, "R5 R8 write", 0, 0, 1, 8'h5A);
        o_wd = 8'h00;
        tick(2);
        expect_st(1, "R8 keeps driving", 0, 0, 1, 8'h5A);
        o_bv = 1; o_bbit = 3'd2; o_bval = 1;
        tick(1);
        o_bv = 0;
        o_hs_n = 1'b0;
        tick(3);
        expect_st(1, "R5 ack releases", 1, 0, 1, 8'h5A);
        o_hs_n = 1'b1;
        tick(3);
        expect_st(1, "R6 intr on ack rise", 1, 1, 1, 8'h5A);
        o_wd = 8'h77; o_wr_n = 1'b0;
        tick(3);
        expect_st(1, "R6 write fall clears", 1, 0, 1, 8'h77);
        o_wr_n = 1'b1;
        tick(3);
        expect_st(1, "R5 second write", 0, 0, 1, 8'h77);
        o_bv = 1; o_bbit = 3'd6; o_bval = 0;
        tick(1);
        o_bv = 0;
        o_hs_n = 1'b0;
        tick(3);
        o_hs_n = 1'b1;
        tick(3);
        expect_st(1, "R7 other index kept enable", 1, 1, 1, 8'h77);

        tick(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule